// File: doc/BRIEF.md
# Replay-Window Issue Entry Array

This block is a small issue window for a pipeline that schedules the consumers of loads as if every load hits. Each slot holds one instruction: a destination tag, a few source tags and a per-source readiness state. A slot wakes up when its source tags are seen on any of three tag buses: an external result bus, the issue bus of this array, or its retire bus. When all its sources are ready, the slot competes for issue. Each cycle at most one slot issues, and its destination tag goes out on the issue bus.

Issuing does not free a slot. The slot stays resident and loads a countdown of `WINDOW` cycles, its window of vulnerability. When the countdown runs out, the instruction counts as verified. The slot then announces its tag on the retire bus and frees itself. Wakeups that came from the issue bus are marked speculative. Wakeups from the external bus, the retire bus or allocation are marked firm.

When a load turns out slower than assumed, the `kill` input is raised for one cycle. In that cycle nothing issues. Every issued slot still inside its window becomes unissued, and every speculative source readiness is withdrawn. The affected instructions therefore issue again once their producers re-announce their tags.

Top module: `replay_issue_window`

## Requirements
- R1: While `rst_n` is low, `occupied` is all zero, `issue_valid` and `retire_valid` are low and `alloc_ready` is high.
- R2: An allocation takes the lowest-numbered free slot, which shows as that bit of `occupied` from the next cycle. `alloc_ready` is low exactly when all slots are occupied, and an allocation request while full is dropped and never issues.
- R3: A source becomes ready when its tag matches `wake_tag` (with `wake_valid`), `issue_tag` (with `issue_valid`) or `retire_tag` (with `retire_valid`). This includes a match in the same cycle the slot is allocated. Source ready bit k of `alloc_srcs_rdy` marks field k of `alloc_srcs` (bits k*TAG_W upward) as already ready.
- R4: Among occupied, not-yet-issued slots with all sources ready, the lowest-numbered slot issues in the same cycle, with its destination on `issue_tag`. At most one slot issues per cycle, and none while `kill` is high.
- R5: An issued slot stays occupied for `WINDOW` further cycles: issued in cycle c, it is occupied through cycle c+WINDOW.
- R6: A slot issued in cycle c raises `retire_valid` with its destination on `retire_tag` in cycle c+WINDOW, and it is free from cycle c+WINDOW+1.
- R7: `kill` makes every issued slot that is not in its last window cycle unissued. Such a slot issues again later and puts its destination on `issue_tag` again.
- R8: `kill` withdraws every source readiness that came only from `issue_tag`, in every slot, including slots that have not issued. Readiness from allocation, `wake_tag` or `retire_tag` is kept.
- R9: A slot in its last window cycle when `kill` arrives retires normally. Its `retire_tag` in that cycle wakes consumers firmly, so they are not affected by that `kill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate one instruction this cycle |
| alloc_dst | input | TAG_W | Destination tag of the new instruction |
| alloc_srcs | input | SRC_N*TAG_W | Source tags, field k in bits k*TAG_W upward |
| alloc_srcs_rdy | input | SRC_N | Source k already available at allocation |
| alloc_ready | output | 1 | At least one slot is free |
| wake_valid | input | 1 | External result tag valid |
| wake_tag | input | TAG_W | External result tag |
| kill | input | 1 | Latency misprediction: replay the window |
| issue_valid | output | 1 | A slot issues this cycle |
| issue_tag | output | TAG_W | Destination tag of the issuing slot |
| retire_valid | output | 1 | A slot reaches the end of its window this cycle |
| retire_tag | output | TAG_W | Destination tag of the verified slot |
| occupied | output | ENTRIES | One bit per slot, set while the slot holds an instruction |

## Verification
Issue and retire are combinational on registered slot state, with `kill` gating issue in the same cycle. An allocation or a wake therefore shows on `issue_valid` one cycle after the stimulus, and a retire shows exactly `WINDOW` cycles after the issue cycle. Freeing and allocation change `occupied` one cycle after their cause. The bench drives inputs on the falling edge and samples every output halfway to the next rising edge, so each expected value in its vector table belongs to the cycle written against it. The replay rows are arranged so that ordering by slot number shows whether a `kill` really withdrew a speculative wakeup, and whether a retire in the same cycle as a `kill` protected its consumer.

// File: rtl/rw_pkg.sv
package rw_pkg;

  // Readiness of one source operand.
  typedef enum logic [1:0] {
    SRC_WAIT = 2'b00,   // producer not yet announced
    SRC_SPEC = 2'b01,   // announced at issue, may still be replayed
    SRC_FIRM = 2'b10    // value known to be good
  } src_st_e;

  // Next readiness of one source for one cycle.
  // A firm announcement always wins, even against a kill in the same cycle.
  function automatic src_st_e src_next(input src_st_e cur,
                                       input logic    firm_hit,
                                       input logic    spec_hit,
                                       input logic    kill);
    src_st_e nxt;
    nxt = cur;
    if (firm_hit) begin
      nxt = SRC_FIRM;
    end else if (kill) begin
      nxt = (cur == SRC_FIRM) ? SRC_FIRM : SRC_WAIT;
    end else if (spec_hit && (cur == SRC_WAIT)) begin
      nxt = SRC_SPEC;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/rw_pick_first.sv
module rw_pick_first #(
  parameter int W = 4
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] gnt,
  output logic         any
);

  // Lowest set bit wins.
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < W; i++) begin
      gnt[i] = req[i] & ~seen;
      seen   = seen | req[i];
    end
    any = seen;
  end

endmodule

// File: rtl/rw_slot.sv
module rw_slot
  import rw_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int SRC_N  = 2,
  parameter int WINDOW = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_en,
  input  logic [TAG_W-1:0]             alloc_dst,
  input  logic [SRC_N-1:0][TAG_W-1:0]  alloc_src,
  input  logic [SRC_N-1:0]             alloc_rdy,
  input  logic                         grant,
  input  logic                         kill,
  input  logic                         ext_v,
  input  logic [TAG_W-1:0]             ext_tag,
  input  logic                         spec_v,
  input  logic [TAG_W-1:0]             spec_tag,
  input  logic                         ret_v,
  input  logic [TAG_W-1:0]             ret_tag,
  output logic                         valid_o,
  output logic                         req_o,
  output logic [TAG_W-1:0]             dst_o,
  output logic                         retire_o
);

  localparam int                TMR_W  = $clog2(WINDOW + 1);
  localparam logic [TMR_W-1:0]  T_ONE  = TMR_W'(1);
  localparam logic [TMR_W-1:0]  T_LOAD = TMR_W'(WINDOW);

  // state registers
  logic                         valid_q,  valid_d;
  logic                         issued_q, issued_d;
  logic [TMR_W-1:0]             timer_q,  timer_d;
  logic [TAG_W-1:0]             dst_q,    dst_d;
  logic [SRC_N-1:0][TAG_W-1:0]  tag_q,    tag_d;
  src_st_e                      st_q [SRC_N];
  src_st_e                      st_d [SRC_N];

  // tag match results, for stored tags and for tags being allocated
  logic [SRC_N-1:0] firm_st, spec_st, firm_al, spec_al;
  logic             all_rdy;
  logic             retiring;
  logic             upd_en;

  always_comb begin
    for (int k = 0; k < SRC_N; k++) begin
      firm_st[k] = (ext_v && (ext_tag == tag_q[k])) ||
                   (ret_v && (ret_tag == tag_q[k]));
      spec_st[k] = spec_v && (spec_tag == tag_q[k]);
      firm_al[k] = (ext_v && (ext_tag == alloc_src[k])) ||
                   (ret_v && (ret_tag == alloc_src[k]));
      spec_al[k] = spec_v && (spec_tag == alloc_src[k]);
    end
  end

  always_comb begin
    all_rdy = 1'b1;
    for (int k = 0; k < SRC_N; k++) begin
      all_rdy = all_rdy & (st_q[k] != SRC_WAIT);
    end
  end

  assign retiring = valid_q & issued_q & (timer_q == T_ONE);
  assign upd_en   = alloc_en | valid_q;

  // next-state process
  always_comb begin
    valid_d  = valid_q;
    issued_d = issued_q;
    timer_d  = timer_q;
    dst_d    = dst_q;
    tag_d    = tag_q;
    for (int k = 0; k < SRC_N; k++) begin
      st_d[k] = st_q[k];
    end

    if (!valid_q) begin
      if (alloc_en) begin
        valid_d  = 1'b1;
        issued_d = 1'b0;
        timer_d  = '0;
        dst_d    = alloc_dst;
        tag_d    = alloc_src;
        for (int k = 0; k < SRC_N; k++) begin
          st_d[k] = src_next(alloc_rdy[k] ? SRC_FIRM : SRC_WAIT,
                             firm_al[k], spec_al[k], kill);
        end
      end
    end else if (retiring) begin
      // verified: leaves the window, a simultaneous kill does not matter
      valid_d  = 1'b0;
      issued_d = 1'b0;
      timer_d  = '0;
    end else begin
      for (int k = 0; k < SRC_N; k++) begin
        st_d[k] = src_next(st_q[k], firm_st[k], spec_st[k], kill);
      end
      if (kill && issued_q) begin
        issued_d = 1'b0;
        timer_d  = '0;
      end else if (grant) begin
        issued_d = 1'b1;
        timer_d  = T_LOAD;
      end else if (issued_q && (timer_q != '0)) begin
        timer_d  = timer_q - T_ONE;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      issued_q <= 1'b0;
      timer_q  <= '0;
      dst_q    <= '0;
      tag_q    <= '0;
      for (int k = 0; k < SRC_N; k++) begin
        st_q[k] <= SRC_WAIT;
      end
    end else if (upd_en) begin
      valid_q  <= valid_d;
      issued_q <= issued_d;
      timer_q  <= timer_d;
      dst_q    <= dst_d;
      tag_q    <= tag_d;
      for (int k = 0; k < SRC_N; k++) begin
        st_q[k] <= st_d[k];
      end
    end
  end

  assign valid_o  = valid_q;
  assign req_o    = valid_q & ~issued_q & all_rdy;
  assign dst_o    = dst_q;
  assign retire_o = retiring;

  // R2: allocation is only steered to an empty slot
  a_r2_alloc_into_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !valid_q);

  // R5: issue starts a full window
  a_r5_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !kill) |=> (valid_q && issued_q && (timer_q == T_LOAD)));

  // R5: window counts down one per cycle
  a_r5_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && issued_q && (timer_q > T_ONE) && !kill) |=>
      (valid_q && (timer_q == $past(timer_q) - T_ONE)));

  // R6: a verified slot is empty on the following cycle
  a_r6_free_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    retiring |=> !valid_q);

  // R7: kill puts an issued slot inside its window back to unissued
  a_r7_kill_unissues: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && issued_q && (timer_q > T_ONE) && kill) |=>
      (valid_q && !issued_q && (timer_q == '0)));

  // R9: last window cycle wins over kill
  a_r9_verify_beats_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (retiring && kill) |=> !valid_q);

  // R8: no speculative readiness survives a kill
  for (genvar k = 0; k < SRC_N; k++) begin : g_src
    a_r8_no_spec_after_kill: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (!valid_q || (st_q[k] != SRC_SPEC)));
  end

endmodule

// File: rtl/replay_issue_window.sv
module replay_issue_window #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 4,
  parameter int SRC_N   = 2,
  parameter int WINDOW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  input  logic [TAG_W-1:0]         alloc_dst,
  input  logic [SRC_N*TAG_W-1:0]   alloc_srcs,
  input  logic [SRC_N-1:0]         alloc_srcs_rdy,
  output logic                     alloc_ready,
  input  logic                     wake_valid,
  input  logic [TAG_W-1:0]         wake_tag,
  input  logic                     kill,
  output logic                     issue_valid,
  output logic [TAG_W-1:0]         issue_tag,
  output logic                     retire_valid,
  output logic [TAG_W-1:0]         retire_tag,
  output logic [ENTRIES-1:0]       occupied
);

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] req_vec;
  logic [ENTRIES-1:0] req_gated;
  logic [ENTRIES-1:0] grant_vec;
  logic [ENTRIES-1:0] free_vec;
  logic [ENTRIES-1:0] free_pick;
  logic [ENTRIES-1:0] alloc_en;
  logic [ENTRIES-1:0] retire_vec;
  logic [TAG_W-1:0]   dst_arr [ENTRIES];

  // allocation: lowest free slot
  assign free_vec = ~valid_vec;

  rw_pick_first #(.W(ENTRIES)) i_alloc_pick (
    .req (free_vec),
    .gnt (free_pick),
    .any (alloc_ready)
  );

  assign alloc_en = alloc_valid ? free_pick : '0;

  // select: lowest ready slot, nothing while a replay is being raised
  assign req_gated = kill ? '0 : req_vec;

  rw_pick_first #(.W(ENTRIES)) i_issue_pick (
    .req (req_gated),
    .gnt (grant_vec),
    .any (issue_valid)
  );

  always_comb begin
    issue_tag = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant_vec[i]) issue_tag = issue_tag | dst_arr[i];
    end
  end

  // at most one slot leaves its window per cycle (one issue per cycle)
  always_comb begin
    retire_tag = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (retire_vec[i]) retire_tag = retire_tag | dst_arr[i];
    end
  end

  assign retire_valid = |retire_vec;
  assign occupied     = valid_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    rw_slot #(
      .TAG_W  (TAG_W),
      .SRC_N  (SRC_N),
      .WINDOW (WINDOW)
    ) i_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (alloc_en[i]),
      .alloc_dst (alloc_dst),
      .alloc_src (alloc_srcs),
      .alloc_rdy (alloc_srcs_rdy),
      .grant     (grant_vec[i]),
      .kill      (kill),
      .ext_v     (wake_valid),
      .ext_tag   (wake_tag),
      .spec_v    (issue_valid),
      .spec_tag  (issue_tag),
      .ret_v     (retire_valid),
      .ret_tag   (retire_tag),
      .valid_o   (valid_vec[i]),
      .req_o     (req_vec[i]),
      .dst_o     (dst_arr[i]),
      .retire_o  (retire_vec[i])
    );
  end

  // R4: one grant at most, and only to a requesting slot
  a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && ((grant_vec & ~req_vec) == '0));

  // R6: window expiries never collide
  a_r6_one_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(retire_vec));

  // R4: winner is the lowest requesting slot
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ((req_vec & (grant_vec - 1'b1)) == '0));

endmodule

// File: tb/test_replay_issue_window.sv
module test_replay_issue_window;

  localparam int ENTRIES = 4;
  localparam int TAG_W   = 4;
  localparam int SRC_N   = 2;
  localparam int WINDOW  = 4;
  localparam int NV      = 35;

  // one row per cycle, one nibble per field (high to low):
  // alloc, dst, src0, src1, src_rdy, wake_v, wake_tag, kill |
  // exp issue_v, issue_tag, retire_v, retire_tag, occupied, req code
  localparam logic [55:0] VEC [0:NV-1] = '{
    56'h1_1_8_9_3_0_0_0__0_0_0_0_0_1,  //  0 load A -> slot0
    56'h1_2_1_1_0_0_0_0__1_1_0_0_1_2,  //  1 A issues, B wakes at alloc
    56'h1_3_2_7_2_0_0_0__1_2_0_0_3_2,  //  2 B issues, C wakes at alloc
    56'h1_5_6_7_3_0_0_0__1_3_0_0_7_0,  //  3 C issues, D independent
    56'h0_0_0_0_0_0_0_1__0_0_0_0_F_3,  //  4 kill, no issue
    56'h0_0_0_0_0_0_0_0__1_1_0_0_F_3,  //  5 A reissues, tag again
    56'h0_0_0_0_0_0_0_0__1_2_0_0_F_3,  //  6
    56'h0_0_0_0_0_0_0_0__1_3_0_0_F_7,  //  7
    56'h0_0_0_0_0_0_0_0__1_5_0_0_F_7,  //  8
    56'h0_0_0_0_0_0_0_0__0_0_1_1_F_6,  //  9 A verified
    56'h0_0_0_0_0_0_0_0__0_0_1_2_E_6,  // 10
    56'h0_0_0_0_0_0_0_0__0_0_1_3_C_6,  // 11
    56'h0_0_0_0_0_0_0_0__0_0_1_5_8_6,  // 12
    56'h1_6_8_9_3_0_0_0__0_0_0_0_0_1,  // 13 E -> slot0
    56'h1_7_6_C_0_0_0_0__1_6_0_0_1_2,  // 14 E issues, F half awake
    56'h0_0_0_0_0_1_C_0__0_0_0_0_3_2,  // 15 external wake of C
    56'h0_0_0_0_0_0_0_0__1_7_0_0_3_2,  // 16 F issues
    56'h0_0_0_0_0_0_0_0__0_0_0_0_3_5,  // 17
    56'h0_0_0_0_0_0_0_1__0_0_1_6_3_5,  // 18 kill while E ends window
    56'h0_0_0_0_0_0_0_0__1_7_0_0_2_5,  // 19 F reissues at once
    56'h0_0_0_0_0_0_0_0__0_0_0_0_2_7,  // 20
    56'h0_0_0_0_0_0_0_0__0_0_0_0_2_7,  // 21
    56'h0_0_0_0_0_0_0_0__0_0_0_0_2_7,  // 22
    56'h0_0_0_0_0_0_0_0__0_0_1_7_2_6,  // 23
    56'h1_9_8_8_0_0_0_0__0_0_0_0_0_1,  // 24 H waits on 8 -> slot0
    56'h1_8_A_B_3_0_0_0__0_0_0_0_1_1,  // 25 G -> slot1
    56'h0_0_0_0_0_0_0_0__1_8_0_0_3_2,  // 26 G issues, H spec awake
    56'h0_0_0_0_0_0_0_1__0_0_0_0_3_4,  // 27 kill
    56'h0_0_0_0_0_0_0_0__1_8_0_0_3_4,  // 28 H no longer ready, G wins
    56'h0_0_0_0_0_0_0_0__1_9_0_0_3_3,  // 29
    56'h0_0_0_0_0_0_0_0__0_0_0_0_3_7,  // 30
    56'h0_0_0_0_0_0_0_0__0_0_0_0_3_7,  // 31
    56'h0_0_0_0_0_0_0_0__0_0_1_8_3_6,  // 32
    56'h0_0_0_0_0_0_0_0__0_0_1_9_1_6,  // 33
    56'h0_0_0_0_0_0_0_0__0_0_0_0_0_6   // 34
  };

  logic                    clk;
  logic                    rst_n;
  logic                    alloc_valid;
  logic [TAG_W-1:0]        alloc_dst;
  logic [SRC_N*TAG_W-1:0]  alloc_srcs;
  logic [SRC_N-1:0]        alloc_srcs_rdy;
  logic                    alloc_ready;
  logic                    wake_valid;
  logic [TAG_W-1:0]        wake_tag;
  logic                    kill;
  logic                    issue_valid;
  logic [TAG_W-1:0]        issue_tag;
  logic                    retire_valid;
  logic [TAG_W-1:0]        retire_tag;
  logic [ENTRIES-1:0]      occupied;

  int checks = 0;
  int errors = 0;

  replay_issue_window #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .SRC_N   (SRC_N),
    .WINDOW  (WINDOW)
  ) i_replay_issue_window (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_valid    (alloc_valid),
    .alloc_dst      (alloc_dst),
    .alloc_srcs     (alloc_srcs),
    .alloc_srcs_rdy (alloc_srcs_rdy),
    .alloc_ready    (alloc_ready),
    .wake_valid     (wake_valid),
    .wake_tag       (wake_tag),
    .kill           (kill),
    .issue_valid    (issue_valid),
    .issue_tag      (issue_tag),
    .retire_valid   (retire_valid),
    .retire_tag     (retire_tag),
    .occupied       (occupied)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  function automatic string row_req(input logic [3:0] c);
    case (c)
      4'd1:    return "R2";
      4'd2:    return "R3";
      4'd3:    return "R7";
      4'd4:    return "R8";
      4'd5:    return "R9";
      4'd6:    return "R6";
      4'd7:    return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic a, input logic [3:0] d, input logic [3:0] s0,
                     input logic [3:0] s1, input logic [1:0] r, input logic ev,
                     input logic [3:0] et, input logic k);
    alloc_valid    = a;
    alloc_dst      = d;
    alloc_srcs     = {s1, s0};
    alloc_srcs_rdy = r;
    wake_valid     = ev;
    wake_tag       = et;
    kill           = k;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    put(1'b0, 4'h0, 4'h0, 4'h0, 2'b00, 1'b0, 4'h0, 1'b0);
    repeat (2) @(negedge clk);
    #5;
    // R1: reset state
    check("R1", "occupied",     32'(occupied),     32'h0);
    check("R1", "issue_valid",  32'(issue_valid),  32'h0);
    check("R1", "retire_valid", 32'(retire_valid), 32'h0);
    check("R1", "alloc_ready",  32'(alloc_ready),  32'h1);
    rst_n = 1'b1;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      string       rq;
      v  = VEC[i];
      rq = row_req(v[3:0]);
      @(negedge clk);
      put(v[52], v[51:48], v[47:44], v[43:40], v[37:36], v[32], v[31:28], v[24]);
      #5;
      check({"R4 ", rq}, $sformatf("issue_valid row %0d", i),
            32'(issue_valid), 32'(v[20]));
      if (v[20]) check({"R4 ", rq}, $sformatf("issue_tag row %0d", i),
                       32'(issue_tag), 32'(v[19:16]));
      check({"R6 ", rq}, $sformatf("retire_valid row %0d", i),
            32'(retire_valid), 32'(v[12]));
      if (v[12]) check({"R6 ", rq}, $sformatf("retire_tag row %0d", i),
                       32'(retire_tag), 32'(v[11:8]));
      check({"R5 ", rq}, $sformatf("occupied row %0d", i),
            32'(occupied), 32'(v[7:4]));
      check("R2", $sformatf("alloc_ready row %0d", i),
            32'(alloc_ready), 32'(v[7:4] != 4'hF));
    end

    // R2: fill every slot with waiters on tag E, then one more request
    for (int j = 0; j < ENTRIES; j++) begin
      @(negedge clk);
      put(1'b1, 4'(10 + j), 4'hE, 4'hE, 2'b00, 1'b0, 4'h0, 1'b0);
    end
    @(negedge clk);
    put(1'b1, 4'hF, 4'h1, 4'h2, 2'b11, 1'b0, 4'h0, 1'b0);
    #5;
    check("R2", "alloc_ready when full", 32'(alloc_ready), 32'h0);
    check("R2", "occupied when full",    32'(occupied),    32'hF);
    @(negedge clk);
    put(1'b0, 4'h0, 4'h0, 4'h0, 2'b00, 1'b1, 4'hE, 1'b0);
    #5;
    check("R3", "no issue before wake", 32'(issue_valid), 32'h0);
    // R4 R3: all four wake firmly, issue in slot order
    for (int j = 0; j < ENTRIES; j++) begin
      @(negedge clk);
      put(1'b0, 4'h0, 4'h0, 4'h0, 2'b00, 1'b0, 4'h0, 1'b0);
      #5;
      check("R4", "slot order issue_valid", 32'(issue_valid), 32'h1);
      check("R4", "slot order issue_tag",   32'(issue_tag),   32'(10 + j));
    end
    @(negedge clk);
    #5;
    check("R2", "dropped request never issues", 32'(issue_valid),  32'h0);
    check("R6", "first waiter verified",        32'(retire_valid), 32'h1);
    check("R6", "first waiter tag",             32'(retire_tag),   32'hA);

    // R1: asynchronous reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    check("R1", "occupied in reset",     32'(occupied),     32'h0);
    check("R1", "retire_valid in reset", 32'(retire_valid), 32'h0);
    check("R1", "issue_valid in reset",  32'(issue_valid),  32'h0);
    check("R1", "alloc_ready in reset",  32'(alloc_ready),  32'h1);

    finish_run();
  end

endmodule